// File: doc/BRIEF.md
# Four-Channel Event PWM with Reloaded Compare Values

The block produces four pulse-width-modulated outputs from one shared up-counter. The counter counts from zero up to a programmable period limit and then returns to zero. The same clock edge that starts a new cycle raises a set event on every channel. Each channel also has a duty compare value. When the counter reaches that value, a clear event fires and pulls the channel low. If a set event and a clear event land on the same tick, the clear event wins. This means a duty value of zero gives a flat low output and never a one-tick spike.

Software writes period and duty values through a simple write port into reload registers. The values in use by the counter and the comparators change only when a new cycle begins, so every cycle runs with one consistent set of values. Each channel also has a force flag that holds the output high for whole cycles. A synchronous run enable starts and stops the block. While it is off, the counter sits at zero and every output is low.

Top module: `pwm_evt_quad`

## Requirements
- R1: After a synchronous reset, every output is low, the period reload value is 63 and every duty value and force flag is zero. If the block is then enabled with no writes, all outputs stay low.
- R2: A cycle has period+1 ticks. The counter shows 0 in the first tick and the period value in the last tick, and then starts a new cycle.
- R3: With duty value D in the range 1 to period, a channel is high for exactly D ticks per cycle. Those are ticks 0 to D-1, and there is one rising edge per cycle. The output is registered and lines up with the tick the counter shows.
- R4: With duty value 0 and the force flag clear, the channel never goes high, because the clear event takes priority over the set event on tick 0.
- R5: A set force flag, or a duty value greater than the period, holds the channel high for every tick of every cycle while the block runs.
- R6: Writes change only the reload registers. The period, duty and force values in use take the reload values on the edge where a new cycle begins. A write made in the middle of a cycle does not affect that cycle.
- R7: While run_en is low, the counter is held at 0 and all outputs are low from the next edge onward. When run_en rises, the next edge starts a full cycle at tick 0 and loads the reload values.
- R8: Write address 0 holds the period in wr_data[5:0]. Address 1+c holds channel c's settings: wr_data[5:0] is the duty value and wr_data[6] is the force flag. Other addresses are ignored.
- R9: Each channel's output depends only on its own duty value and force flag, together with the shared counter and period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Synchronous run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 period, 1..4 channels) |
| wr_data | input | 7 | Write data: bit 6 force, bits 5:0 value |
| pwm_out | output | 4 | Registered channel outputs |

## Verification
The assertions assume only that run_en and the write port are synchronous to clk. They also assume the values in use change only on a set event, so the counter can never be above the period in use. To stay within this, the stimulus drives every input on the falling edge. It also lets at least two full cycles pass after each reprogramming before it counts high ticks. For the mid-cycle reload tests, the stimulus uses a duty-1 marker channel to find tick 0. It then writes on a known tick, which places each write strictly inside a cycle.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int unsigned PERIOD_ADDR = 0;

  typedef enum logic [1:0] {
    LVL_HOLD = 2'd0,
    LVL_SET  = 2'd1,
    LVL_CLR  = 2'd2
  } lvl_act_e;

  // Clear has priority over set so that a zero duty never emits a pulse.
  function automatic lvl_act_e pick_action(input logic set_e, input logic clr_e);
    lvl_act_e a;
    if (clr_e)      a = LVL_CLR;
    else if (set_e) a = LVL_SET;
    else            a = LVL_HOLD;
    return a;
  endfunction

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs #(
  parameter int CNT_W  = 6,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CNT_W:0]                 wr_data,
  input  logic                           load,
  output logic [CNT_W-1:0]               per_shd,
  output logic [CNT_W-1:0]               per_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]   duty_shd,
  output logic [NUM_CH-1:0][CNT_W-1:0]   duty_act,
  output logic [NUM_CH-1:0]              frc_shd,
  output logic [NUM_CH-1:0]              frc_act
);
  import pwm_evt_pkg::*;

  localparam logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(PERIOD_ADDR);

  logic per_hit;
  assign per_hit = wr_en && (wr_addr == PER_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          per_shd <= '1;
    else if (per_hit) per_shd <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       per_act <= '1;
    else if (load) per_act <= per_shd;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ch + 1);
    logic hit;
    assign hit = wr_en && (wr_addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_shd[ch] <= '0;
        frc_shd[ch]  <= 1'b0;
      end else if (hit) begin
        duty_shd[ch] <= wr_data[CNT_W-1:0];
        frc_shd[ch]  <= wr_data[CNT_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_act[ch] <= '0;
        frc_act[ch]  <= 1'b0;
      end else if (load) begin
        duty_act[ch] <= duty_shd[ch];
        frc_act[ch]  <= frc_shd[ch];
      end
    end
  end

endmodule

// File: rtl/pwm_evt_timebase.sv
module pwm_evt_timebase #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             running,
  output logic             set_evt
);
  logic wrap;

  assign wrap    = running && (cnt == per_act);
  // Start-up and wrap both begin a cycle at tick 0.
  assign set_evt = run_en && (!running || wrap);

  always_comb begin
    if (!running || wrap) cnt_nxt = '0;
    else                  cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      running <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm_evt_channel.sv
module pwm_evt_channel #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             set_evt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] duty_now,
  input  logic             frc_now,
  output logic             pwm_q
);
  import pwm_evt_pkg::*;

  logic     clr_evt;
  lvl_act_e act;

  assign clr_evt = !frc_now && (cnt_nxt == duty_now);
  assign act     = pick_action(set_evt, clr_evt);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      pwm_q <= 1'b0;
    end else begin
      case (act)
        LVL_CLR: pwm_q <= 1'b0;
        LVL_SET: pwm_q <= 1'b1;
        default: pwm_q <= pwm_q;
      endcase
    end
  end

endmodule

// File: rtl/pwm_evt_quad.sv
module pwm_evt_quad #(
  parameter  int CNT_W  = 6,
  parameter  int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W:0]    wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [CNT_W-1:0]             per_shd, per_act;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_shd, duty_act;
  logic [NUM_CH-1:0]            frc_shd, frc_act;
  logic [CNT_W-1:0]             cnt_q, cnt_nxt;
  logic                         running, set_evt;

  pwm_evt_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(set_evt), .per_shd(per_shd), .per_act(per_act),
    .duty_shd(duty_shd), .duty_act(duty_act), .frc_shd(frc_shd), .frc_act(frc_act)
  );

  pwm_evt_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run_en(run_en), .per_act(per_act),
    .cnt(cnt_q), .cnt_nxt(cnt_nxt), .running(running), .set_evt(set_evt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    logic [CNT_W-1:0] duty_now;
    logic             frc_now;
    // On a set event the cycle about to start uses the reload values.
    assign duty_now = set_evt ? duty_shd[ch] : duty_act[ch];
    assign frc_now  = set_evt ? frc_shd[ch]  : frc_act[ch];

    pwm_evt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run_en(run_en), .set_evt(set_evt),
      .cnt_nxt(cnt_nxt), .duty_now(duty_now), .frc_now(frc_now),
      .pwm_q(pwm_out[ch])
    );
  end

endmodule

// File: rtl/pwm_evt_quad_chk.sv
module pwm_evt_quad_chk #(
  parameter int CNT_W  = 6,
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         run_en,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [CNT_W-1:0]             cnt,
  input logic                         running,
  input logic                         set_evt,
  input logic [CNT_W-1:0]             per_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_act,
  input logic [NUM_CH-1:0]            frc_act
);

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_act);

  assert_idle_cnt_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == '0));

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (pwm_out == '0 && cnt == '0 && !running));

  assert_reload_only_at_start_R6: assert property (@(posedge clk) disable iff (rst)
    !set_evt |=> ($stable(per_act) && $stable(duty_act) && $stable(frc_act)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (rst)
      (duty_act[ch] == '0 && !frc_act[ch]) |-> !pwm_out[ch]);

    assert_force_high_R5: assert property (@(posedge clk) disable iff (rst)
      (running && frc_act[ch]) |-> pwm_out[ch]);

    assert_tick0_high_R3: assert property (@(posedge clk) disable iff (rst)
      (running && cnt == '0 && duty_act[ch] != '0) |-> pwm_out[ch]);
  end

endmodule

bind pwm_evt_quad pwm_evt_quad_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .pwm_out(pwm_out), .cnt(cnt_q),
  .running(running), .set_evt(set_evt), .per_act(per_act),
  .duty_act(duty_act), .frc_act(frc_act)
);

// File: tb/tb_pwm_evt_quad.sv
module tb_pwm_evt_quad;
  localparam int CW  = 6;
  localparam int NCH = 4;
  localparam int AW  = 3;
  localparam int DW  = CW + 1;
  localparam logic [DW-1:0] FRC = 7'h40;

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_out;

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  pwm_evt_quad #(.CNT_W(CW), .NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .run_en(run_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [CW-1:0]           per;
    logic [NCH-1:0][DW-1:0]  duty;   // {ch3, ch2, ch1, ch0}
    logic [NCH-1:0][6:0]     hi;     // expected high ticks per cycle
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{6'd63, {7'd63, 7'd32, 7'd1, 7'd0},        {7'd63, 7'd32, 7'd1, 7'd0}},
    '{6'd63, {7'd10, 7'd0, 7'd63, FRC},         {7'd10, 7'd0, 7'd63, 7'd64}},
    '{6'd9,  {7'd20, 7'd9, 7'd0, 7'd3},         {7'd10, 7'd9, 7'd0, 7'd3}},
    '{6'd0,  {7'd0, FRC, 7'd1, 7'd0},           {7'd0, 7'd1, 7'd1, 7'd0}},
    '{6'd31, {FRC | 7'd5, 7'd32, 7'd31, 7'd16}, {7'd32, 7'd32, 7'd31, 7'd16}}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = AW'(a);
    wr_data = DW'(d);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic measure(input int len, output int hi [NCH], output int rs [NCH]);
    logic [NCH-1:0] prev;
    prev = pwm_out;
    for (int c = 0; c < NCH; c++) begin hi[c] = 0; rs[c] = 0; end
    repeat (len) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pwm_out[c]) hi[c]++;
        if (pwm_out[c] && !prev[c]) rs[c]++;
      end
      prev = pwm_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi [NCH];
    int rs [NCH];
    logic p3;

    // R1: reset state
    step(3);
    check("R1", "outputs in reset", int'(pwm_out), 0);
    rst = 1'b0;
    run_en = 1'b1;
    measure(130, hi, rs);
    for (int c = 0; c < NCH; c++) check("R1", "default duty high ticks", hi[c], 0);

    // R2 R3 R5 R8 R9: vector table
    foreach (VECS[v]) begin
      wr(0, int'(VECS[v].per));
      for (int c = 0; c < NCH; c++) wr(c + 1, int'(VECS[v].duty[c]));
      step(140);
      measure(int'(VECS[v].per) + 1, hi, rs);
      for (int c = 0; c < NCH; c++)
        check("R3/R5/R8/R9", $sformatf("vec %0d ch %0d high ticks", v, c), hi[c], int'(VECS[v].hi[c]));
    end

    // R3 R4: full sweep of duty on channel 0 with period 63
    wr(0, 63);
    for (int d = 0; d < 64; d++) begin
      wr(1, d);
      step(130);
      measure(64, hi, rs);
      check(d == 0 ? "R4" : "R3", $sformatf("duty %0d high ticks", d), hi[0], d);
      check(d == 0 ? "R4" : "R3", $sformatf("duty %0d rising edges", d), rs[0], (d == 0) ? 0 : 1);
    end

    // R6: mid-cycle writes take effect at the next cycle start
    wr(4, 1);      // channel 3 marker, high on tick 0 only
    wr(1, 40);
    wr(2, 0);
    wr(3, int'(FRC));
    step(140);
    p3 = pwm_out[3];
    forever begin
      @(negedge clk);
      if (pwm_out[3] && !p3) break;
      p3 = pwm_out[3];
    end
    // tick 0 now visible
    step(10);
    wr(1, 5);      // tick 10 -> 11
    wr(0, 31);     // tick 11 -> 12
    step(8);       // tick 20
    check("R6", "old duty kept at tick 20", int'(pwm_out[0]), 1);
    step(12);      // tick 32
    check("R6", "old period kept at tick 32", int'(pwm_out[3]), 0);
    step(13);      // tick 45
    check("R6", "old duty clears at 40", int'(pwm_out[0]), 0);
    step(18);      // tick 63
    check("R2", "marker low on last tick", int'(pwm_out[3]), 0);
    step(1);       // new cycle tick 0
    check("R2", "marker high at wrap", int'(pwm_out[3]), 1);
    check("R6", "new duty starts high", int'(pwm_out[0]), 1);
    step(4);
    check("R6", "new duty high at tick 4", int'(pwm_out[0]), 1);
    step(1);
    check("R6", "new duty low at tick 5", int'(pwm_out[0]), 0);
    step(27);      // tick 32 = next start with period 31
    check("R2", "new period wraps after 32 ticks", int'(pwm_out[3]), 1);
    step(1);
    check("R2", "marker one tick wide", int'(pwm_out[3]), 0);

    // R7: stop and restart
    @(negedge clk);
    run_en = 1'b0;
    step(1);
    check("R7", "outputs low after stop", int'(pwm_out), 0);
    measure(20, hi, rs);
    check("R7", "forced channel low while stopped", hi[2], 0);
    run_en = 1'b1;
    step(1);
    check("R7", "restart tick 0 outputs", int'(pwm_out), 4'b1101);
    step(1);
    check("R7", "marker low at tick 1", int'(pwm_out[3]), 0);
    step(31);
    check("R7", "first cycle full 32 ticks", int'(pwm_out[3]), 1);
    check("R5", "forced channel high", int'(pwm_out[2]), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule